// File: doc/BRIEF.md
# 384-bit ARX Permutation Engine

This block applies an iterative keyless permutation to a 384-bit state. The state is six 64-bit branches, and each branch is a pair of 32-bit words (x, y). A caller presents a full state and a step count and pulses `start`. The engine then computes one complete step per clock cycle. A step has three parts. First, a step-dependent constant is injected. Next, an add-rotate-xor box is applied to every branch. Last, a linear mixing layer runs and the branch order is rotated.

The finished state appears on `state_out`, and `done` pulses for one cycle. The result stays on `state_out` until the next accepted start. Hashing and authenticated-encryption modes built around the permutation are the job of surrounding logic.

Top module: `arx384_perm`

## Requirements
- R1: After reset, `busy` and `done` are low and `state_out` is all zero.
- R2: `start` while idle samples `state_in` and `steps_in`. For a count N of 1 or more, `busy` is high for exactly the N cycles that follow, and one step is computed in each of those cycles.
- R3: `done` is a one-cycle pulse. It is seen in the cycle after the last step, together with the final state on `state_out`.
- R4: A count of 0 gives a `done` pulse in the cycle after `start`, with `busy` staying low and `state_out` equal to the sampled input.
- R5: State packing: word k sits at bits [32k+31:32k], where word 2i is x of branch i and word 2i+1 is y of branch i. At the beginning of step s (counting from 0), y0 is XORed with C[s mod 8] and y1 with s zero-extended. C = B7E15162, BF715880, 38B4DA56, 324E7738, BB1185EB, 4F7C7B57, CFBFA1C8, C2B3293D (hex, index 0 first).
- R6: Branch i is transformed by a four-round box keyed with C[i]. Each round does, in order: x += y rotated right by a, then y ^= x rotated right by b, then x ^= C[i]. The (a,b) pairs per round are (31,24), (17,17), (0,31), (24,16).
- R7: After the boxes, let tx be the XOR of x0, x1, x2 and ty the XOR of y0, y1, y2, and let L(t) = (t ^ (t<<16)) rotated right by 16. Each right branch j in 3..5 becomes x = xj^x(j-3)^L(ty) and y = yj^y(j-3)^L(tx). The new branches 0,1,2 are the updated old 4,5,3, and the new branches 3,4,5 are the old 0,1,2.
- R8: A `start` while `busy` is ignored. The running job finishes on time with a result computed from its own input.
- R9: While idle with no `start`, `state_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job; sampled only when idle |
| steps_in | input | CW (4) | Number of steps for the job |
| state_in | input | 384 | Initial state, packed as in R5 |
| busy | output | 1 | High while steps are being computed |
| done | output | 1 | One-cycle completion pulse |
| state_out | output | 384 | Current or final state |

## Verification
A wrong constant, rotation amount or branch routing corrupts every later step. It therefore shows as a mismatch across most of `state_out` at the `done` pulse of any job with a count of one or more. A one-step job pins down the faulty stage directly. A counter or handshake fault shows within a single job as `done` arriving a cycle early or late, `busy` held for the wrong number of cycles, or a restart caused by a `start` that should have been ignored. Sweeping all sixteen counts over several input patterns exposes each of these faults at the first job that triggers it.

// File: rtl/arx384_pkg.sv
package arx384_pkg;
  localparam int WORD_W  = 32;
  localparam int NBR     = 6;
  localparam int HALF    = NBR / 2;
  localparam int STATE_W = 2 * WORD_W * NBR;

  function automatic logic [WORD_W-1:0] rcon(input int idx);
    case (idx % 8)
      0: return 32'hB7E15162;
      1: return 32'hBF715880;
      2: return 32'h38B4DA56;
      3: return 32'h324E7738;
      4: return 32'hBB1185EB;
      5: return 32'h4F7C7B57;
      6: return 32'hCFBFA1C8;
      default: return 32'hC2B3293D;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] ror32(input logic [WORD_W-1:0] v, input int n);
    return (v >> n) | (v << (WORD_W - n));
  endfunction

  function automatic logic [WORD_W-1:0] ell(input logic [WORD_W-1:0] t);
    return ror32(t ^ (t << 16), 16);
  endfunction

  // four add-rotate-xor rounds on one branch; returns {x, y}
  function automatic logic [2*WORD_W-1:0] arxbox(input logic [WORD_W-1:0] xi,
                                                 input logic [WORD_W-1:0] yi,
                                                 input logic [WORD_W-1:0] c);
    logic [WORD_W-1:0] x, y;
    x = xi; y = yi;
    x = x + ror32(y, 31); y = y ^ ror32(x, 24); x = x ^ c;
    x = x + ror32(y, 17); y = y ^ ror32(x, 17); x = x ^ c;
    x = x + y;            y = y ^ ror32(x, 31); x = x ^ c;
    x = x + ror32(y, 24); y = y ^ ror32(x, 16); x = x ^ c;
    return {x, y};
  endfunction
endpackage

// File: rtl/arx384_box.sv
module arx384_box
  import arx384_pkg::*;
#(
  parameter int CIDX = 0
) (
  input  logic [WORD_W-1:0] xi,
  input  logic [WORD_W-1:0] yi,
  output logic [WORD_W-1:0] xo,
  output logic [WORD_W-1:0] yo
);
  always_comb {xo, yo} = arxbox(xi, yi, rcon(CIDX));
endmodule

// File: rtl/arx384_step.sv
module arx384_step
  import arx384_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic [STATE_W-1:0] cur,
  input  logic [CW-1:0]      idx,
  output logic [STATE_W-1:0] nxt
);
  logic [STATE_W-1:0] inj_s;
  logic [WORD_W-1:0]  ax [NBR];
  logic [WORD_W-1:0]  ay [NBR];
  logic [WORD_W-1:0]  mx [HALF];
  logic [WORD_W-1:0]  my [HALF];
  logic [WORD_W-1:0]  tx, ty, lx, ly;

  // constant injection into y0 and y1
  always_comb begin
    inj_s = cur;
    inj_s[WORD_W +: WORD_W]   = cur[WORD_W +: WORD_W] ^ rcon(int'(idx));
    inj_s[3*WORD_W +: WORD_W] = cur[3*WORD_W +: WORD_W] ^ WORD_W'(idx);
  end

  for (genvar b = 0; b < NBR; b++) begin : g_box
    arx384_box #(.CIDX(b)) u_box (
      .xi(inj_s[(2*b)*WORD_W +: WORD_W]),
      .yi(inj_s[(2*b+1)*WORD_W +: WORD_W]),
      .xo(ax[b]),
      .yo(ay[b])
    );
  end

  // mixing of left parity into right half, then branch rotation
  always_comb begin
    tx = '0;
    ty = '0;
    for (int i = 0; i < HALF; i++) begin
      tx = tx ^ ax[i];
      ty = ty ^ ay[i];
    end
    lx = ell(tx);
    ly = ell(ty);
    for (int j = 0; j < HALF; j++) begin
      mx[j] = ax[j+HALF] ^ ax[j] ^ ly;
      my[j] = ay[j+HALF] ^ ay[j] ^ lx;
    end
    nxt = '0;
    for (int j = 0; j < HALF; j++) begin
      nxt[(2*j)*WORD_W +: WORD_W]          = mx[(j+1) % HALF];
      nxt[(2*j+1)*WORD_W +: WORD_W]        = my[(j+1) % HALF];
      nxt[(2*(j+HALF))*WORD_W +: WORD_W]   = ax[j];
      nxt[(2*(j+HALF)+1)*WORD_W +: WORD_W] = ay[j];
    end
  end
endmodule

// File: rtl/arx384_ctrl.sv
module arx384_ctrl #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] steps_in,
  output logic          busy,
  output logic          done,
  output logic          load,
  output logic [CW-1:0] step_idx
);
  logic [CW-1:0] cnt_q, lim_q;
  logic          busy_q, done_q;
  logic          last_step;
  logic          zero_job;

  assign load      = start && !busy_q;
  assign zero_job  = load && (steps_in == '0);
  assign last_step = busy_q && (cnt_q == lim_q - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lim_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        lim_q <= steps_in;
        cnt_q <= '0;
        if (zero_job) done_q <= 1'b1;
        else          busy_q <= 1'b1;
      end else if (busy_q) begin
        cnt_q <= cnt_q + CW'(1);
        if (last_step) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign step_idx = cnt_q;

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < lim_q));
  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_step) |=> (busy_q && cnt_q == $past(cnt_q) + CW'(1)));
  // R4
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_job |=> (done_q && !busy_q));
endmodule

// File: rtl/arx384_perm.sv
module arx384_perm
  import arx384_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [CW-1:0]      steps_in,
  input  logic [STATE_W-1:0] state_in,
  output logic               busy,
  output logic               done,
  output logic [STATE_W-1:0] state_out
);
  logic               load;
  logic [CW-1:0]      step_idx;
  logic [STATE_W-1:0] state_q, state_nx;

  arx384_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .steps_in(steps_in),
    .busy(busy), .done(done), .load(load), .step_idx(step_idx)
  );

  arx384_step #(.CW(CW)) u_step (
    .cur(state_q), .idx(step_idx), .nxt(state_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    state_q <= '0;
    else if (load) state_q <= state_in;
    else if (busy) state_q <= state_nx;
  end

  assign state_out = state_q;

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(state_q));
endmodule

// File: tb/sim_arx384_perm.sv
module sim_arx384_perm;
  typedef logic [31:0] wv_t [12];

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [3:0]   steps_in = '0;
  logic [383:0] state_in = '0;
  logic         busy, done;
  logic [383:0] state_out;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  arx384_perm u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .steps_in(steps_in),
    .state_in(state_in), .busy(busy), .done(done), .state_out(state_out)
  );

  function automatic logic [31:0] rol(input logic [31:0] v, input int n);
    return (n == 0) ? v : ((v << n) | (v >> (32 - n)));
  endfunction

  function automatic logic [31:0] kc(input int i);
    logic [31:0] t [8];
    t = '{32'hB7E15162, 32'hBF715880, 32'h38B4DA56, 32'h324E7738,
          32'hBB1185EB, 32'h4F7C7B57, 32'hCFBFA1C8, 32'hC2B3293D};
    return t[i & 7];
  endfunction

  function automatic wv_t model(input wv_t w0, input int n);
    wv_t w, o;
    logic [31:0] x, y, px, py, fx, fy;
    w = w0;
    for (int s = 0; s < n; s++) begin
      w[1] ^= kc(s);
      w[3] ^= 32'(s);
      for (int b = 0; b < 6; b++) begin
        x = w[2*b]; y = w[2*b+1];
        x += rol(y, 1);  y ^= rol(x, 8);  x ^= kc(b);
        x += rol(y, 15); y ^= rol(x, 15); x ^= kc(b);
        x += y;          y ^= rol(x, 1);  x ^= kc(b);
        x += rol(y, 8);  y ^= rol(x, 16); x ^= kc(b);
        w[2*b] = x; w[2*b+1] = y;
      end
      px = w[0] ^ w[2] ^ w[4];
      py = w[1] ^ w[3] ^ w[5];
      fx = rol(px ^ {px[15:0], 16'h0}, 16);
      fy = rol(py ^ {py[15:0], 16'h0}, 16);
      o[6] = w[0]; o[7] = w[1]; o[8] = w[2]; o[9] = w[3]; o[10] = w[4]; o[11] = w[5];
      o[4] = w[6]  ^ w[0] ^ fy; o[5] = w[7]  ^ w[1] ^ fx;
      o[0] = w[8]  ^ w[2] ^ fy; o[1] = w[9]  ^ w[3] ^ fx;
      o[2] = w[10] ^ w[4] ^ fy; o[3] = w[11] ^ w[5] ^ fx;
      w = o;
    end
    return w;
  endfunction

  function automatic logic [383:0] pack(input wv_t w);
    logic [383:0] p;
    for (int k = 0; k < 12; k++) p[k*32 +: 32] = w[k];
    return p;
  endfunction

  function automatic wv_t pattern(input int seed);
    wv_t w;
    for (int k = 0; k < 12; k++) begin
      case (seed)
        0: w[k] = 32'h0;
        1: w[k] = 32'hFFFFFFFF;
        2: w[k] = 32'(k) * 32'h01010101;
        default: w[k] = (32'(seed) * 32'h9E3779B9) ^ (32'(k) * 32'h85EBCA6B) ^ 32'h5A5A0F0F;
      endcase
    end
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [383:0] act, input logic [383:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run(input int seed, input int n, input bit intrude);
    wv_t w;
    logic [383:0] exp, held;
    w = pattern(seed);
    exp = pack(model(w, n));
    @(negedge clk);
    start = 1'b1; steps_in = 4'(n); state_in = pack(w);
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= n + 1; k++) begin
      if (k > 1) @(negedge clk);
      if (intrude && k == 2) begin
        start = 1'b1; steps_in = 4'd1; state_in = ~pack(w);
      end else begin
        start = 1'b0;
      end
      check(done == (k == n + 1), (n == 0) ? "R4" : (intrude ? "R8" : "R3"),
            "done timing", 384'(done), 384'(k == n + 1));
      check(busy == (k <= n), (n == 0) ? "R4" : "R2", "busy window",
            384'(busy), 384'(k <= n));
    end
    start = 1'b0;
    check(state_out == exp, (n == 0) ? "R4" : (n == 1 ? "R5 R6 R7" : "R3 R5 R6 R7"),
          "result", state_out, exp);
    held = state_out;
    repeat (2) @(negedge clk);
    check(state_out == held && !done, "R9", "idle hold", state_out, held);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog timeout actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done && state_out == '0, "R1", "reset", {busy, done, state_out[381:0]}, '0);
    rst_n = 1'b1;
    for (int seed = 0; seed < 5; seed++)
      for (int n = 0; n < 16; n++)
        run(seed, n, (seed == 3 && n >= 3));
    run(4, 11, 1'b1); // R8
    run(2, 7, 1'b1);  // R8
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule